// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for a chip. A sixteen-state controller advances on each rising edge of the test clock, steered by the mode-select input. Through a 3-bit instruction register the port selects one of three data registers and places it between the serial input and the serial output. The three data registers are a one-bit pass-through stage, a 32-bit identity word and a boundary chain.

The boundary chain loads from a parallel capture bus when a data capture happens. It drives a parallel update bus when a data update happens under a boundary instruction. The serial output changes on the falling edge of the test clock, and its enable is high only while a register is shifting.

An asynchronous active-low reset puts the controller in Test-Logic-Reset. Holding mode-select high for five clocks also reaches Test-Logic-Reset. Either way the identity instruction becomes the current instruction.

Top module: `jtag_tap_port`

## Requirements
- R1: The controller follows the standard sixteen-state graph, with TMS sampled on each rising TCK edge. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: While trst_n is low the controller is in Test-Logic-Reset, the current instruction is IDCODE, bscan_upd is all zeros and tdo_oe is low.
- R3: The instruction register is 3 bits wide and shifts in Shift-IR with TDI entering at bit 2 and bit 0 driving TDO. Capture-IR loads 3'b001, so the first bit out is 1 and the next two are 0.
- R4: The current instruction changes only in Update-IR, where it takes the shifted value. Test-Logic-Reset sets it to IDCODE.
- R5: The instruction codes are IDCODE = 3'b001, BYPASS = 3'b111, boundary drive = 3'b000 and boundary sample = 3'b010. The codes 3'b011, 3'b100, 3'b101 and 3'b110 select the bypass stage.
- R6: Under IDCODE, Capture-DR loads the word {ID_REV[2:0], ID_PART[16:0], ID_MFR[10:0], 1'b1}, which holds bits 31:29, 28:12, 11:1 and 0. Shift-DR sends it out bit 0 first, and TDI follows it after 32 shifts.
- R7: Under a bypass code, a one-bit stage captures 0 in Capture-DR and then passes TDI to TDO with a delay of one shift.
- R8: Under either boundary code, Capture-DR loads bscan_cap into the BSR_LEN-bit chain. Shift-DR sends out bit 0 first and TDI enters at bit BSR_LEN-1.
- R9: bscan_upd changes only in Update-DR and only under a boundary code, where it takes the chain contents. Under any other code a data scan leaves it unchanged.
- R10: TDO changes on the falling edge of TCK. tdo_oe is high exactly during Shift-IR and Shift-DR, including the Shift-DR that follows Capture-DR.
- R11: Passing through Exit1-DR, Pause-DR and Exit2-DR back to Shift-DR keeps the data register contents, so the scan continues where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| bscan_cap | input | BSR_LEN | Parallel values captured into the boundary chain |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for tdo, high only while shifting |
| bscan_upd | output | BSR_LEN | Parallel boundary update outputs |

## Verification
The bench builds the port with a 7-bit boundary chain and a non-trivial identity word (revision 5, part 0x1A2B3, maker 0x0B5). With that configuration a 40-bit data scan runs past the end of every data register. The bench sweeps all eight instruction codes. For each code it checks the captured instruction pattern, the full shifted-out stream (including TDI emerging behind the selected register) and whether the update bus moves. A short chain also makes the pause path, the five-ones reset from different states and the asynchronous reset cheap to check.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int unsigned IR_W = 3;
    localparam int unsigned ID_W = 32;

    localparam logic [IR_W-1:0] OP_BND_DRIVE  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE     = 3'b001;
    localparam logic [IR_W-1:0] OP_BND_SAMPLE = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS     = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE    = 3'b001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_ID,
        SEL_BSR
    } dr_sel_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.st = tap_next(s_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            s_q.st <= ST_TLR;
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q.st;

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_e       state,
    output logic             ir_lsb,
    output logic [IR_W-1:0]  ir_cur,
    output dr_sel_e          dr_sel
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] cur;
    } ir_t;

    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_TLR:    r_d.cur = OP_IDCODE;
            ST_CAP_IR: r_d.sh  = IR_CAPTURE;
            ST_SH_IR:  r_d.sh  = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.cur = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sh  <= IR_CAPTURE;
            r_q.cur <= OP_IDCODE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.cur)
            OP_IDCODE:                   dr_sel = SEL_ID;
            OP_BND_DRIVE, OP_BND_SAMPLE: dr_sel = SEL_BSR;
            default:                     dr_sel = SEL_BYPASS;
        endcase
    end

    assign ir_lsb = r_q.sh[0];
    assign ir_cur = r_q.cur;

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int unsigned        BSR_LEN = 107,
    parameter logic [ID_W-1:0]    ID_WORD = 32'h1
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            dr_sel,
    input  logic [BSR_LEN-1:0] cap_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] upd_out
);

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bsr;
        logic [BSR_LEN-1:0] upd;
    } dr_t;

    dr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_CAP_DR: begin
                case (dr_sel)
                    SEL_ID:  r_d.id  = ID_WORD;
                    SEL_BSR: r_d.bsr = cap_in;
                    default: r_d.byp = 1'b0;
                endcase
            end
            ST_SH_DR: begin
                case (dr_sel)
                    SEL_ID:  r_d.id  = {tdi, r_q.id[ID_W-1:1]};
                    SEL_BSR: r_d.bsr = {tdi, r_q.bsr[BSR_LEN-1:1]};
                    default: r_d.byp = tdi;
                endcase
            end
            ST_UPD_DR: begin
                if (dr_sel == SEL_BSR) begin
                    r_d.upd = r_q.bsr;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (dr_sel)
            SEL_ID:  dr_lsb = r_q.id[0];
            SEL_BSR: dr_lsb = r_q.bsr[0];
            default: dr_lsb = r_q.byp;
        endcase
    end

    assign upd_out = r_q.upd;

endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
    import jtag_tap_pkg::*;
#(
    parameter int unsigned  BSR_LEN = 107,
    parameter logic [2:0]   ID_REV  = 3'h0,
    parameter logic [16:0]  ID_PART = 17'h1A885,
    parameter logic [10:0]  ID_MFR  = 11'h034
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bscan_cap,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bscan_upd
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_MFR, 1'b1};

    tap_state_e      tap_st;
    logic [IR_W-1:0] ir_cur;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_e         dr_sel;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_st)
    );

    jtag_tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (tap_st),
        .ir_lsb (ir_lsb),
        .ir_cur (ir_cur),
        .dr_sel (dr_sel)
    );

    jtag_tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (tap_st),
        .dr_sel  (dr_sel),
        .cap_in  (bscan_cap),
        .dr_lsb  (dr_lsb),
        .upd_out (bscan_upd)
    );

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.oe  = (tap_st == ST_SH_IR) || (tap_st == ST_SH_DR);
        o_d.tdo = (tap_st == ST_SH_IR) ? ir_lsb : dr_lsb;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tdo    = o_q.tdo;
    assign tdo_oe = o_q.oe;

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 107
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdo_oe,
    input  logic [BSR_LEN-1:0] bscan_upd,
    input  tap_state_e         tap_st,
    input  logic [IR_W-1:0]    ir_cur
);

    // R1
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (tap_st == ST_TLR));

    // R4
    tlr_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_st == ST_TLR) |=> (ir_cur == OP_IDCODE));

    // R4
    ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_st != ST_UPD_IR && tap_st != ST_TLR) |=> $stable(ir_cur));

    // R9
    upd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_st != ST_UPD_DR) |=> $stable(bscan_upd));

    // R9
    upd_nonbsr_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_cur != OP_BND_DRIVE && ir_cur != OP_BND_SAMPLE) |=> $stable(bscan_upd));

    // R10
    oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((tap_st == ST_SH_DR) || (tap_st == ST_SH_IR)));

endmodule

bind jtag_tap_port jtag_tap_chk #(.BSR_LEN(BSR_LEN)) i_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdo_oe    (tdo_oe),
    .bscan_upd (bscan_upd),
    .tap_st    (tap_st),
    .ir_cur    (ir_cur)
);

// File: tb/test_jtag_tap_port.sv
module test_jtag_tap_port;

    localparam int unsigned BL   = 7;
    localparam logic [2:0]  REV  = 3'h5;
    localparam logic [16:0] PART = 17'h1A2B3;
    localparam logic [10:0] MFR  = 11'h0B5;
    localparam int          NSH  = 40;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BL-1:0] bscan_cap = '0;
    logic          tdo;
    logic          tdo_oe;
    logic [BL-1:0] bscan_upd;

    int checks = 0;
    int fails  = 0;

    always #4 tck = ~tck;

    jtag_tap_port #(
        .BSR_LEN (BL),
        .ID_REV  (REV),
        .ID_PART (PART),
        .ID_MFR  (MFR)
    ) i_jtag_tap_port (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .tdi       (tdi),
        .bscan_cap (bscan_cap),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .bscan_upd (bscan_upd)
    );

    function automatic logic [63:0] id_expect();
        longint v;
        v = longint'(REV) * (64'd1 << 29) + longint'(PART) * (64'd1 << 12)
          + longint'(MFR) * 2 + 1;
        return 64'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1;
        o   = tdo;
        e   = tdo_oe;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o, e;
        tick(1'b1, 1'b0, o, e);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i], o, e);
            cap[i] = o;
        end
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din,
                           output logic [63:0] dout, output bit oe_ok);
        logic o, e;
        dout  = '0;
        oe_ok = 1'b1;
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        if (e) oe_ok = 1'b0;
        tick(1'b0, 1'b0, o, e);
        if (e) oe_ok = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o, e);
            dout[i] = o;
            if (!e) oe_ok = 1'b0;
        end
        tick(1'b1, 1'b0, o, e);
        if (e) oe_ok = 1'b0;
        tick(1'b0, 1'b0, o, e);
        if (e) oe_ok = 1'b0;
        @(negedge tck);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] dout, exp, idw, din;
        logic [2:0]  cap;
        logic [BL-1:0] prev_upd, exp_upd;
        logic o, e;
        bit oe_ok;

        idw = id_expect();

        // R2: reset state
        repeat (3) @(posedge tck);
        @(negedge tck);
        #1;
        chk(tdo_oe == 1'b0, "R2 tdo_oe in reset", 64'(tdo_oe), 64'h0);
        chk(bscan_upd == '0, "R2 bscan_upd in reset", 64'(bscan_upd), 64'h0);
        trst_n = 1'b1;
        tick(1'b0, 1'b0, o, e);

        // R6: IDCODE is current after reset
        scan_dr(32, 64'h0, dout, oe_ok);
        chk(dout[31:0] == idw[31:0], "R6 ID word after reset", dout, idw);
        chk(oe_ok, "R10 tdo_oe only in shift", 64'(oe_ok), 64'h1);

        // R5 R7 R8 R9: sweep all instruction codes
        prev_upd = '0;
        for (int c = 0; c < 8; c++) begin
            bscan_cap = BL'((c * 37 + 11) % (1 << BL));
            scan_ir(3'(c), cap);
            // R3: captured pattern 001, bit 0 out first
            chk(cap == 3'b001, "R3 IR capture pattern", 64'(cap), 64'h1);
            din = '0;
            for (int i = 0; i < NSH; i++) din[i] = ((i * 5 + c) % 3) == 0;
            scan_dr(NSH, din, dout, oe_ok);
            exp = '0;
            exp_upd = prev_upd;
            for (int i = 0; i < NSH; i++) begin
                if (c == 0 || c == 2)
                    exp[i] = (i < BL) ? bscan_cap[i] : din[i - BL];
                else if (c == 1)
                    exp[i] = (i < 32) ? idw[i] : din[i - 32];
                else
                    exp[i] = (i == 0) ? 1'b0 : din[i - 1];
            end
            if (c == 0 || c == 2)
                for (int j = 0; j < BL; j++) exp_upd[j] = din[NSH - BL + j];
            chk(dout[NSH-1:0] == exp[NSH-1:0], "R5 R7 R8 selected register stream",
                dout, exp);
            chk(bscan_upd == exp_upd, "R9 update bus after data scan",
                64'(bscan_upd), 64'(exp_upd));
            chk(oe_ok, "R10 tdo_oe only in shift", 64'(oe_ok), 64'h1);
            prev_upd = bscan_upd;
        end

        // R11: pause in the middle of an ID scan
        scan_ir(3'b001, cap);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        dout = '0;
        for (int i = 0; i < 32; i++) begin
            tick(i == 15 || i == 31, 1'b0, o, e);
            dout[i] = o;
            if (i == 15) begin
                tick(1'b0, 1'b0, o, e);
                tick(1'b0, 1'b0, o, e);
                tick(1'b1, 1'b0, o, e);
                tick(1'b0, 1'b0, o, e);
            end
        end
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        chk(dout[31:0] == idw[31:0], "R11 scan resumes after pause", dout, idw);

        // R1 R4: five TMS-high clocks from Shift-DR restore IDCODE
        scan_ir(3'b111, cap);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        scan_dr(32, 64'h0, dout, oe_ok);
        chk(dout[31:0] == idw[31:0], "R1 five ones from Shift-DR", dout, idw);

        // R1 R4: five TMS-high clocks from Pause-IR
        scan_ir(3'b000, cap);
        tick(1'b1, 1'b0, o, e);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b0, o, e);
        scan_dr(32, 64'h0, dout, oe_ok);
        chk(dout[31:0] == idw[31:0], "R4 five ones from Pause-IR", dout, idw);

        // R2: asynchronous reset mid-run
        scan_ir(3'b000, cap);
        din = 64'h55;
        scan_dr(BL, din, dout, oe_ok);
        chk(bscan_upd == BL'(din), "R9 update bus loaded", 64'(bscan_upd), din);
        #2;
        trst_n = 1'b0;
        #3;
        chk(bscan_upd == '0, "R2 async reset clears update bus", 64'(bscan_upd), 64'h0);
        @(posedge tck);
        #1;
        trst_n = 1'b1;
        tick(1'b0, 1'b0, o, e);
        scan_dr(32, 64'h0, dout, oe_ok);
        chk(dout[31:0] == idw[31:0], "R2 IDCODE after async reset", dout, idw);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule